// File: doc/BRIEF.md
# Two-dimensional Haar packet decomposer

The block takes a square tile of signed samples, one sample per clock, and splits it into four packet subbands. It uses a single level of two-tap Haar filtering in each dimension, built only from adders and subtractors. The row pass replaces every horizontally adjacent pair with its sum and its difference. The column pass then does the same to every vertically adjacent pair of the row-pass result. Both the low branch and the high branch are split, so the tile comes out as four quarter-size subbands. No normalisation is applied, so each low-low coefficient is the plain sum of a 2x2 neighbourhood.

Words are in sign-magnitude form. A small counter-driven controller sequences the work in four steps: it loads the tile, latches the row pass, latches the column pass, and then streams the coefficients out, one per cycle, with each one tagged by its subband. A sticky flag reports when any intermediate or final magnitude had to be clamped. The input stays stalled from the last accepted sample until the last coefficient of that tile has been delivered.

Top module: `hpk_decomp`

## Requirements
- R1: Every word is `WIDTH` bits. The top bit is the sign (1 = negative) and the low `WIDTH-1` bits are the magnitude. For example, with `WIDTH`=16 the value -1 is 0x8001, and with `WIDTH`=6 it is 0x21.
- R2: `in_ready_o` is high while idle. It accepts exactly `SIDE*SIDE` samples in row-major order (row 0 column 0 first). It is low from the edge that accepts the last sample until the edge after the last coefficient.
- R3: The row pass maps the pair at columns 2k and 2k+1 to low = left + right and high = left - right. The column pass maps the pair at rows 2k and 2k+1 to low = upper + lower and high = upper - lower.
- R4: Each low-low coefficient equals the plain sum of its 2x2 neighbourhood. For the 4x4 tile with rows [1 1 0 1], [2 1 1 0], [0 2 1 1], [3 0 1 2], the low-low subband is [5 2; 5 5].
- R5: Subbands are emitted in id order 3, 2, 1, 0, each in row-major order. In the id, bit 1 set means the high branch of the row pass and bit 0 set means the high branch of the column pass. Id 3 is high-high and id 0 is low-low.
- R6: If the last sample is accepted at edge k, `out_valid_o` is high from edge k+2 to edge k+2+`SIDE*SIDE`, and low at all other times.
- R7: When the operand signs differ, the result takes the sign of the larger magnitude. A zero result always has a clear sign bit, including when the inputs are negative zeros.
- R8: A magnitude above 2^(`WIDTH`-1)-1 is clamped to that maximum, and the sign is kept. This applies in both passes.
- R9: `ovf_o` rises when any clamp occurs in a tile. It then holds until the first sample of the next tile is accepted.
- R10: `in_valid_i` and `in_data_i` have no effect while `in_ready_o` is low. They alter neither the coefficients of the tile in flight nor the tile loaded next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Sample accepted this cycle if offered |
| in_data_i | input | WIDTH | Sign-magnitude sample |
| out_valid_o | output | 1 | Coefficient present |
| out_band_o | output | 2 | Subband id of the coefficient |
| out_data_o | output | WIDTH | Sign-magnitude coefficient |
| ovf_o | output | 1 | Sticky clamp indicator for the current tile |

## Verification
The bench builds the block with `SIDE`=4 and `WIDTH`=6, which gives a magnitude ceiling of 31. At that width a single pair sum can clamp, so both passes and the flag are easy to reach. Negative zeros and equal magnitudes of opposite sign also occur often in pseudo-random tiles. Two hundred tiles are swept: the known tile, all-zero, all-maximum, all-minimum and negative-zero tiles, then alternating small-range and full-range tiles. Each coefficient, its band id and its cycle are compared against an integer model. Every other tile is driven with junk on the input while the block is busy.

// File: rtl/hpk_pkg.sv
package hpk_pkg;
  typedef enum logic [1:0] {
    ST_LOAD,
    ST_ROWS,
    ST_COLS,
    ST_EMIT
  } hpk_state_e;

  // band id bits: [1] row-pass high branch, [0] column-pass high branch
  localparam logic [1:0] BAND_HH = 2'd3;
  localparam logic [1:0] BAND_LL = 2'd0;
endpackage

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] y_o,
  output logic             sat_o
);
  localparam int MW = WIDTH - 1;
  localparam logic [MW-1:0] MAXM = {MW{1'b1}};

  logic          sa, sb, sgn;
  logic [MW-1:0] ma, mb, mag;
  logic [MW:0]   sum;

  always_comb begin
    sa    = a_i[WIDTH-1];
    sb    = b_i[WIDTH-1] ^ sub_i;
    ma    = a_i[MW-1:0];
    mb    = b_i[MW-1:0];
    sum   = {1'b0, ma} + {1'b0, mb};
    sat_o = 1'b0;
    if (sa == sb) begin
      sat_o = sum[MW];
      mag   = sum[MW] ? MAXM : sum[MW-1:0];
      sgn   = sa;
    end else if (ma >= mb) begin
      mag = ma - mb;
      sgn = sa;
    end else begin
      mag = mb - ma;
      sgn = sb;
    end
    // zero is always encoded positive
    if (mag == '0) sgn = 1'b0;
    y_o = {sgn, mag};
  end
endmodule

// File: rtl/haar_stage.sv
module haar_stage #(
  parameter int WIDTH = 16,
  parameter int SIDE  = 4,
  parameter bit VERT  = 1'b0
) (
  input  logic [WIDTH-1:0] x_i [SIDE*SIDE],
  output logic [WIDTH-1:0] y_o [SIDE*SIDE],
  output logic             ovf_o
);
  localparam int H  = SIDE / 2;
  localparam int NA = 2 * SIDE * H;

  logic [NA-1:0] sat;

  for (genvar p = 0; p < SIDE; p++) begin : g_line
    for (genvar k = 0; k < H; k++) begin : g_pair
      localparam int IA = VERT ? (2*k)*SIDE + p   : p*SIDE + 2*k;
      localparam int IB = VERT ? (2*k+1)*SIDE + p : p*SIDE + 2*k + 1;
      localparam int IL = VERT ? k*SIDE + p       : p*SIDE + k;
      localparam int IH = VERT ? (k+H)*SIDE + p   : p*SIDE + k + H;
      localparam int SI = 2 * (p*H + k);

      sm_addsub #(.WIDTH(WIDTH)) u_lo (
        .a_i  (x_i[IA]),
        .b_i  (x_i[IB]),
        .sub_i(1'b0),
        .y_o  (y_o[IL]),
        .sat_o(sat[SI])
      );
      sm_addsub #(.WIDTH(WIDTH)) u_hi (
        .a_i  (x_i[IA]),
        .b_i  (x_i[IB]),
        .sub_i(1'b1),
        .y_o  (y_o[IH]),
        .sat_o(sat[SI+1])
      );
    end
  end

  assign ovf_o = |sat;
endmodule

// File: rtl/haar_ctrl.sv
module haar_ctrl
  import hpk_pkg::*;
#(
  parameter int SIDE = 4,
  localparam int IW  = $clog2(SIDE*SIDE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic          wr_en_o,
  output logic          first_acc_o,
  output logic [IW-1:0] idx_o,
  output logic          row_latch_o,
  output logic          col_latch_o,
  output logic          emit_o
);
  localparam logic [IW-1:0] LAST = IW'(SIDE*SIDE - 1);

  hpk_state_e    state_q;
  logic [IW-1:0] cnt_q;
  logic          last_c;

  assign last_c = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: if (in_valid_i) begin
          cnt_q <= last_c ? '0 : cnt_q + 1'b1;
          if (last_c) state_q <= ST_ROWS;
        end
        ST_ROWS: state_q <= ST_COLS;
        ST_COLS: begin
          state_q <= ST_EMIT;
          cnt_q   <= '0;
        end
        ST_EMIT: begin
          cnt_q <= last_c ? '0 : cnt_q + 1'b1;
          if (last_c) state_q <= ST_LOAD;
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_LOAD);
  assign wr_en_o     = in_ready_o && in_valid_i;
  assign first_acc_o = wr_en_o && (cnt_q == '0);
  assign idx_o       = cnt_q;
  assign row_latch_o = (state_q == ST_ROWS);
  assign col_latch_o = (state_q == ST_COLS);
  assign emit_o      = (state_q == ST_EMIT);
endmodule

// File: rtl/hpk_decomp.sv
module hpk_decomp #(
  parameter int WIDTH = 16,
  parameter int SIDE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] in_data_i,
  output logic             out_valid_o,
  output logic [1:0]       out_band_o,
  output logic [WIDTH-1:0] out_data_o,
  output logic             ovf_o
);
  localparam int NN = SIDE * SIDE;
  localparam int IW = $clog2(NN);
  localparam int LH = $clog2(SIDE) - 1;

  logic [WIDTH-1:0] x_q  [NN];
  logic [WIDTH-1:0] s1_d [NN];
  logic [WIDTH-1:0] s1_q [NN];
  logic [WIDTH-1:0] s2_d [NN];
  logic [WIDTH-1:0] s2_q [NN];

  logic          wr_en, first_acc, row_latch, col_latch, emit;
  logic          ovf1, ovf2, ovf_q;
  logic [IW-1:0] idx;

  haar_ctrl #(.SIDE(SIDE)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .wr_en_o    (wr_en),
    .first_acc_o(first_acc),
    .idx_o      (idx),
    .row_latch_o(row_latch),
    .col_latch_o(col_latch),
    .emit_o     (emit)
  );

  haar_stage #(.WIDTH(WIDTH), .SIDE(SIDE), .VERT(1'b0)) u_rows (
    .x_i  (x_q),
    .y_o  (s1_d),
    .ovf_o(ovf1)
  );

  haar_stage #(.WIDTH(WIDTH), .SIDE(SIDE), .VERT(1'b1)) u_cols (
    .x_i  (s1_q),
    .y_o  (s2_d),
    .ovf_o(ovf2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NN; i++) begin
        x_q[i]  <= '0;
        s1_q[i] <= '0;
        s2_q[i] <= '0;
      end
      ovf_q <= 1'b0;
    end else begin
      if (wr_en) x_q[idx] <= in_data_i;
      if (row_latch) s1_q <= s1_d;
      if (col_latch) s2_q <= s2_d;
      if (first_acc) ovf_q <= 1'b0;
      else if ((row_latch && ovf1) || (col_latch && ovf2)) ovf_q <= 1'b1;
    end
  end

  // emit index: [order(2) | row in band | col in band]; band id = ~order
  logic [1:0]      band;
  logic [LH-1:0]   r_in, c_in;
  logic [IW-1:0]   sel;

  always_comb begin
    band = ~idx[IW-1 -: 2];
    r_in = idx[2*LH-1:LH];
    c_in = idx[LH-1:0];
    // row half chosen by column-pass branch, column half by row-pass branch
    sel  = {band[0], r_in, band[1], c_in};
  end

  assign out_valid_o = emit;
  assign out_band_o  = emit ? band : 2'd0;
  assign out_data_o  = emit ? s2_q[sel] : '0;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/hpk_decomp_chk.sv
module hpk_decomp_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [1:0]       out_band_o,
  input logic [WIDTH-1:0] out_data_o,
  input logic             ovf_o
);
  // R2
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R5
  band_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_band_o == 2'd3);

  // R5
  band_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |->
      (out_band_o == $past(out_band_o) || out_band_o == $past(out_band_o) - 2'd1));

  // R6
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_band_o) == 2'd0);

  // R7
  zero_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_data_o[WIDTH-2:0] == '0) |-> !out_data_o[WIDTH-1]);

  // R9
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(in_valid_i && in_ready_o)) |=> ovf_o);

  // R9
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> !$past(in_ready_o));
endmodule

bind hpk_decomp hpk_decomp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_band_o (out_band_o),
  .out_data_o (out_data_o),
  .ovf_o      (ovf_o)
);

// File: tb/hpk_decomp_test.sv
`timescale 1ns/1ps
module hpk_decomp_test;
  localparam int W    = 6;
  localparam int SIDE = 4;
  localparam int NN   = 16;
  localparam int MAXM = 31;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [1:0]   out_band;
  logic [W-1:0] out_data;
  logic         ovf;

  always #2 clk = ~clk;

  hpk_decomp #(.WIDTH(W), .SIDE(SIDE)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_band_o (out_band),
    .out_data_o (out_data),
    .ovf_o      (ovf)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  bit [31:0] lfsr = 32'h1d872b41;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] rnd();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 17;
    lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  function automatic int dec(logic [W-1:0] w);
    int m = int'(w[W-2:0]);
    return w[W-1] ? -m : m;
  endfunction

  function automatic logic [W-1:0] enc(int v, inout bit of);
    int a = (v < 0) ? -v : v;
    logic [W-2:0] m;
    if (a > MAXM) begin
      a  = MAXM;
      of = 1'b1;
    end
    m = a[W-2:0];
    return {(v < 0) && (a != 0), m};
  endfunction

  logic [W-1:0] x [NN];
  logic [W-1:0] s1 [NN];
  logic [W-1:0] s2 [NN];
  bit exp_ovf;

  task automatic model();
    exp_ovf = 1'b0;
    for (int r = 0; r < SIDE; r++)
      for (int k = 0; k < 2; k++) begin
        int a = dec(x[r*4 + 2*k]);
        int b = dec(x[r*4 + 2*k + 1]);
        s1[r*4 + k]     = enc(a + b, exp_ovf);
        s1[r*4 + k + 2] = enc(a - b, exp_ovf);
      end
    for (int c = 0; c < SIDE; c++)
      for (int k = 0; k < 2; k++) begin
        int a = dec(s1[(2*k)*4 + c]);
        int b = dec(s1[(2*k+1)*4 + c]);
        s2[k*4 + c]       = enc(a + b, exp_ovf);
        s2[(k+2)*4 + c]   = enc(a - b, exp_ovf);
      end
  endtask

  task automatic build(input int kind);
    int ex [16] = '{1,1,0,1, 2,1,1,0, 0,2,1,1, 3,0,1,2};
    for (int i = 0; i < NN; i++) begin
      bit [31:0] v = rnd();
      case (kind)
        0: x[i] = ex[i][W-1:0];
        1: x[i] = '0;
        2: x[i] = {1'b0, 5'd31};
        3: x[i] = {1'b1, 5'd31};
        4: x[i] = {1'b1, 5'd0};
        5: x[i] = {i[0], 5'(i + 3)};
        default: x[i] = kind[0] ? v[W-1:0] : {v[8], 2'b00, v[2:0]};
      endcase
    end
  endtask

  task automatic run_block(input int kind);
    string tag;
    bit    garb = kind[0] && kind > 5;
    build(kind);
    model();
    case (kind)
      0: tag = "R4";
      2, 3: tag = "R8";
      4, 5: tag = "R7";
      default: tag = garb ? "R10" : ((kind % 4 == 2) ? "R1" : "R3");
    endcase
    for (int i = 0; i < NN; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 ready during load", in_ready, 1);
      in_valid = 1'b1;
      in_data  = x[i];
    end
    @(negedge clk);
    in_valid = garb;
    in_data  = rnd();
    chk(in_ready == 1'b0, "R2 busy", in_ready, 0);
    chk(out_valid == 1'b0, "R6 early", out_valid, 0);
    chk(ovf == 1'b0, "R9 cleared", ovf, 0);
    @(negedge clk);
    in_data = rnd();
    chk(out_valid == 1'b0, "R6 early", out_valid, 0);
    for (int j = 0; j < NN; j++) begin
      int b = 3 - j / 4;
      int w = j % 4;
      int e = ((w / 2) + (b % 2) * 2) * 4 + (w % 2) + (b / 2) * 2;
      @(negedge clk);
      chk(out_valid == 1'b1, "R6 window", out_valid, 1);
      chk(out_band == 2'(b), "R5 band", out_band, b);
      chk(out_data == s2[e], tag, out_data, s2[e]);
      if (kind == 0 && b == 0) begin
        int ll [4] = '{5, 2, 5, 5};
        chk(dec(out_data) == ll[w], "R4 example LL", dec(out_data), ll[w]);
      end
      in_data = rnd();
      if (j == NN - 1) in_valid = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 end", out_valid, 0);
    chk(in_ready == 1'b1, "R2 ready again", in_ready, 1);
    chk(ovf == exp_ovf, "R9 flag", ovf, exp_ovf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && ovf == 1'b0,
        "R2 reset state", {in_ready, out_valid, ovf}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 200; t++) run_block(t);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule